// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the purely combinational execute unit of a 32-bit integer pipeline. Each cycle it receives the 6-bit primary opcode and the 6-bit function field of an instruction, the two register operands that were read for it, and the 16-bit immediate field. It returns the value to be written back, a flag that raises a signed-overflow exception, a flag that marks the instruction as unrecognised, and the enable for the register write.

A small decoder inside the block turns the opcode and function field into an operation and a choice of second operand: the register value, the immediate with its sign bit replicated, or the immediate padded with zeros. The add, subtract and both kinds of compare all go through one shared adder. Only the trapping add and subtract forms can raise the overflow flag. When they do, the write enable drops so that the destination register keeps its old value. Exception vectoring is left to the pipeline around the block.

Top module: `ialu_trap`

## Requirements
- R1: With opcode 000000, function 100000 (add) and 100001 (addu) return src_a + src_b, and 100010 (sub) and 100011 (subu) return src_a - src_b, in both cases modulo 2^32.
- R2: add (function 100000), sub (function 100010) and addi (opcode 001000) raise ovf_trap exactly when the true signed result lies outside the 32-bit two's complement range.
- R3: addu, subu and addiu (opcode 001001) never raise ovf_trap.
- R4: slt (function 101010) and slti (opcode 001010) return 1 when the first operand is below the second as signed integers, and 0 otherwise.
- R5: sltu (function 101011) and sltiu (opcode 001011) compare the operands as unsigned integers and return 1 or 0. sltiu compares against the sign-extended immediate.
- R6: The logic functions are and 100100, or 100101, xor 100110 and nor 100111. Each returns the bitwise result of src_a and src_b.
- R7: addi, addiu, slti and sltiu (opcodes 8 to 11) use imm16 with bit 15 copied into bits 31..16, and ignore src_b.
- R8: andi, ori and xori (opcodes 12, 13 and 14) use imm16 with zeros in bits 31..16, so andi always returns zero in the upper half, and ignore src_b.
- R9: lui (opcode 001111) returns imm16 in bits 31..16 and zeros in bits 15..0, whatever the operands.
- R10: Any other opcode, or opcode 000000 with any other function value, sets rsvd_insn and returns a zero result with ovf_trap and wr_en low.
- R11: wr_en is high for every recognised operation unless ovf_trap is set, and it is never high together with ovf_trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Primary opcode field of the instruction |
| fn_code | input | 6 | Function field, used when op_code is 000000 |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field of the instruction |
| result | output | 32 | Value to write back |
| ovf_trap | output | 1 | Signed-overflow exception request |
| rsvd_insn | output | 1 | Unrecognised opcode or function |
| wr_en | output | 1 | Register write enable |

## Verification
The assertions check, for every input combination, these properties: a write never happens together with a trap; a reserved encoding produces a zero result and stays quiet; the unsigned add forms never trap; any trap that an add raises follows from the operand and result signs; the compares return only 0 or 1; lui and andi return the right upper and lower halves. Whether each result is numerically correct, whether overflow is caught at exactly the range boundaries, and whether each immediate is extended the right way are shown only by the bench. The bench sweeps every function code and every opcode across corner-value operands and checks each case against a model that uses wide integer arithmetic.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  // Operations carried out by the execute datapath
  typedef enum logic [3:0] {
    ALU_ADD, ALU_ADDU, ALU_SUB, ALU_SUBU,
    ALU_SLT, ALU_SLTU,
    ALU_AND, ALU_OR, ALU_NOR, ALU_XOR,
    ALU_LUI, ALU_NOP
  } alu_op_e;

  // Source of the second operand
  typedef enum logic [1:0] {
    SRC_REG, SRC_SEXT, SRC_ZEXT
  } src_sel_e;

  typedef struct packed {
    alu_op_e  op;
    src_sel_e src;
    logic     trap_en;
    logic     illegal;
  } dec_t;

  // Primary opcodes
  localparam logic [5:0] OPC_SPECIAL = 6'b000000;
  localparam logic [5:0] OPC_ADDI    = 6'b001000;
  localparam logic [5:0] OPC_ADDIU   = 6'b001001;
  localparam logic [5:0] OPC_SLTI    = 6'b001010;
  localparam logic [5:0] OPC_SLTIU   = 6'b001011;
  localparam logic [5:0] OPC_ANDI    = 6'b001100;
  localparam logic [5:0] OPC_ORI     = 6'b001101;
  localparam logic [5:0] OPC_XORI    = 6'b001110;
  localparam logic [5:0] OPC_LUI     = 6'b001111;

  // Function field values under OPC_SPECIAL
  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_SUB  = 6'b100010;
  localparam logic [5:0] FN_SUBU = 6'b100011;
  localparam logic [5:0] FN_AND  = 6'b100100;
  localparam logic [5:0] FN_OR   = 6'b100101;
  localparam logic [5:0] FN_XOR  = 6'b100110;
  localparam logic [5:0] FN_NOR  = 6'b100111;
  localparam logic [5:0] FN_SLT  = 6'b101010;
  localparam logic [5:0] FN_SLTU = 6'b101011;

endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
  import ialu_pkg::*;
(
  input  logic [5:0] op_code,
  input  logic [5:0] fn_code,
  output dec_t       dec
);

  dec_t fn_dec;

  // Function-field decode for register-register forms
  always_comb begin
    fn_dec = '{op: ALU_NOP, src: SRC_REG, trap_en: 1'b0, illegal: 1'b0};
    case (fn_code)
      FN_ADD:  begin fn_dec.op = ALU_ADD;  fn_dec.trap_en = 1'b1; end
      FN_ADDU: fn_dec.op = ALU_ADDU;
      FN_SUB:  begin fn_dec.op = ALU_SUB;  fn_dec.trap_en = 1'b1; end
      FN_SUBU: fn_dec.op = ALU_SUBU;
      FN_SLT:  fn_dec.op = ALU_SLT;
      FN_SLTU: fn_dec.op = ALU_SLTU;
      FN_AND:  fn_dec.op = ALU_AND;
      FN_OR:   fn_dec.op = ALU_OR;
      FN_NOR:  fn_dec.op = ALU_NOR;
      FN_XOR:  fn_dec.op = ALU_XOR;
      default: fn_dec.illegal = 1'b1;
    endcase
  end

  // Opcode decode; immediates pick their extension here
  always_comb begin
    dec = '{op: ALU_NOP, src: SRC_REG, trap_en: 1'b0, illegal: 1'b0};
    case (op_code)
      OPC_SPECIAL: dec = fn_dec;
      OPC_ADDI:  begin dec.op = ALU_ADD;  dec.src = SRC_SEXT; dec.trap_en = 1'b1; end
      OPC_ADDIU: begin dec.op = ALU_ADDU; dec.src = SRC_SEXT; end
      OPC_SLTI:  begin dec.op = ALU_SLT;  dec.src = SRC_SEXT; end
      OPC_SLTIU: begin dec.op = ALU_SLTU; dec.src = SRC_SEXT; end
      OPC_ANDI:  begin dec.op = ALU_AND;  dec.src = SRC_ZEXT; end
      OPC_ORI:   begin dec.op = ALU_OR;   dec.src = SRC_ZEXT; end
      OPC_XORI:  begin dec.op = ALU_XOR;  dec.src = SRC_ZEXT; end
      OPC_LUI:   dec.op = ALU_LUI;
      default:   dec.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/ialu_operand.sv
module ialu_operand
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  src_sel_e          sel,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sext;
  logic [DATA_W-1:0] imm_zext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_sext = {{PAD_W{imm[IMM_W-1]}}, imm};
      assign imm_zext = {{PAD_W{1'b0}}, imm};
    end else begin : g_nopad
      assign imm_sext = imm[DATA_W-1:0];
      assign imm_zext = imm[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    case (sel)
      SRC_SEXT: opnd_b = imm_sext;
      SRC_ZEXT: opnd_b = imm_zext;
      default:  opnd_b = src_b;
    endcase
  end

endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  alu_op_e           op,
  input  logic              trap_en,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] res,
  output logic              ovf
);

  localparam int MSB   = DATA_W - 1;
  localparam int LOW_W = DATA_W - IMM_W;

  logic              do_sub;
  logic [DATA_W-1:0] b_inv;
  logic [DATA_W:0]   sum_ext;
  logic [DATA_W-1:0] sum;
  logic              carry;
  logic              lt_s;
  logic              lt_u;
  logic              ovf_raw;
  logic [DATA_W-1:0] lui_val;

  // One adder serves add, subtract and both compares
  always_comb begin
    do_sub = (op == ALU_SUB) || (op == ALU_SUBU) ||
             (op == ALU_SLT) || (op == ALU_SLTU);
    b_inv   = do_sub ? ~opnd_b : opnd_b;
    sum_ext = {1'b0, opnd_a} + {1'b0, b_inv} + {{DATA_W{1'b0}}, do_sub};
    sum     = sum_ext[MSB:0];
    carry   = sum_ext[DATA_W];
  end

  // Compares: unsigned from the borrow, signed from the signs
  always_comb begin
    lt_u = ~carry;
    lt_s = (opnd_a[MSB] != opnd_b[MSB]) ? opnd_a[MSB] : sum[MSB];
  end

  // Signed overflow from the operand and result signs (b_inv covers subtract)
  always_comb begin
    ovf_raw = (opnd_a[MSB] == b_inv[MSB]) && (sum[MSB] != opnd_a[MSB]);
    ovf     = trap_en && ovf_raw;
  end

  assign lui_val = {imm, {LOW_W{1'b0}}};

  always_comb begin
    case (op)
      ALU_ADD, ALU_ADDU,
      ALU_SUB, ALU_SUBU: res = sum;
      ALU_SLT:           res = {{MSB{1'b0}}, lt_s};
      ALU_SLTU:          res = {{MSB{1'b0}}, lt_u};
      ALU_AND:           res = opnd_a & opnd_b;
      ALU_OR:            res = opnd_a | opnd_b;
      ALU_NOR:           res = ~(opnd_a | opnd_b);
      ALU_XOR:           res = opnd_a ^ opnd_b;
      ALU_LUI:           res = lui_val;
      default:           res = '0;
    endcase
  end

endmodule

// File: rtl/ialu_trap.sv
module ialu_trap
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [5:0]        op_code,
  input  logic [5:0]        fn_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm16,
  output logic [DATA_W-1:0] result,
  output logic              ovf_trap,
  output logic              rsvd_insn,
  output logic              wr_en
);

  dec_t              dec;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] exec_res;
  logic              exec_ovf;

  ialu_decode u_dec (
    .op_code (op_code),
    .fn_code (fn_code),
    .dec     (dec)
  );

  ialu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .src_b  (src_b),
    .imm    (imm16),
    .sel    (dec.src),
    .opnd_b (opnd_b)
  );

  ialu_exec #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_exec (
    .op      (dec.op),
    .trap_en (dec.trap_en),
    .opnd_a  (src_a),
    .opnd_b  (opnd_b),
    .imm     (imm16),
    .res     (exec_res),
    .ovf     (exec_ovf)
  );

  always_comb begin
    rsvd_insn = dec.illegal;
    ovf_trap  = exec_ovf & ~dec.illegal;
    result    = dec.illegal ? '0 : exec_res;
    wr_en     = ~dec.illegal & ~exec_ovf;
  end

endmodule

// File: rtl/ialu_checker.sv
module ialu_checker
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [5:0]        op_code,
  input logic [5:0]        fn_code,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [IMM_W-1:0]  imm16,
  input logic [DATA_W-1:0] result,
  input logic              ovf_trap,
  input logic              rsvd_insn,
  input logic              wr_en
);

  localparam int MSB   = DATA_W - 1;
  localparam int LOW_W = DATA_W - IMM_W;

  logic is_r;
  logic unsigned_arith;
  logic is_cmp;
  logic is_add_trap;

  always_comb begin
    is_r           = (op_code == OPC_SPECIAL);
    unsigned_arith = (op_code == OPC_ADDIU) ||
                     (is_r && (fn_code == FN_ADDU || fn_code == FN_SUBU));
    is_cmp         = (op_code == OPC_SLTI) || (op_code == OPC_SLTIU) ||
                     (is_r && (fn_code == FN_SLT || fn_code == FN_SLTU));
    is_add_trap    = is_r && (fn_code == FN_ADD);
  end

  always_comb begin
    p_no_write_on_trap_r11: assert (!(ovf_trap && wr_en));
    p_reserved_quiet_r10: assert (!rsvd_insn || (result == '0 && !wr_en && !ovf_trap));
    if (unsigned_arith) begin
      p_no_overflow_r3: assert (!ovf_trap);
    end
    if (is_add_trap && ovf_trap) begin
      p_add_trap_signs_r2: assert ((src_a[MSB] == src_b[MSB]) && (result[MSB] != src_a[MSB]));
    end
    if (is_cmp) begin
      p_compare_bool_r4: assert (result[MSB:1] == '0);
    end
    if (op_code == OPC_LUI) begin
      p_upper_imm_r9: assert (result == {imm16, {LOW_W{1'b0}}});
    end
    if (op_code == OPC_ANDI) begin
      p_andi_upper_zero_r8: assert (result[MSB:IMM_W] == '0);
    end
  end

endmodule

bind ialu_trap ialu_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .op_code   (op_code),
  .fn_code   (fn_code),
  .src_a     (src_a),
  .src_b     (src_b),
  .imm16     (imm16),
  .result    (result),
  .ovf_trap  (ovf_trap),
  .rsvd_insn (rsvd_insn),
  .wr_en     (wr_en)
);

// File: tb/test_ialu_trap.sv
`timescale 1ns/1ps
module test_ialu_trap;

  logic        clk;
  logic [5:0]  op_code;
  logic [5:0]  fn_code;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [15:0] imm16;
  logic [31:0] result;
  logic        ovf_trap;
  logic        rsvd_insn;
  logic        wr_en;

  int n_vec;
  int n_bad;
  bit finished;

  logic [31:0] vals [12] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002,
                             32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                             32'hFFFF_FFFE, 32'h0000_FFFF, 32'hFFFF_0000,
                             32'h1234_5678, 32'h8000_0001, 32'h55AA_33CC};
  logic [15:0] imms [12] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                             16'hFFFF, 16'h1234, 16'h8001, 16'h00FF,
                             16'hFF00, 16'h5555, 16'hAAAA, 16'h7FFE};

  ialu_trap i_ialu_trap (
    .op_code   (op_code),
    .fn_code   (fn_code),
    .src_a     (src_a),
    .src_b     (src_b),
    .imm16     (imm16),
    .result    (result),
    .ovf_trap  (ovf_trap),
    .rsvd_insn (rsvd_insn),
    .wr_en     (wr_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  function automatic bit out_of_range(input longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  // Reference model written from the requirements with wide arithmetic
  task automatic model(input logic [5:0] opc, input logic [5:0] fnc,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im,
                       output logic [31:0] er, output logic eo,
                       output logic ers, output logic ewe,
                       output string tag);
    longint sa, sb, si;
    logic [31:0] sx, zx;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    si = longint'($signed(im));
    sx = {{16{im[15]}}, im};
    zx = {16'h0000, im};
    er = 32'h0; eo = 1'b0; ers = 1'b0; tag = "R10";
    if (opc == 6'd0) begin
      case (fnc)
        6'd32: begin er = a + b; eo = out_of_range(sa + sb); tag = "R1"; end
        6'd33: begin er = a + b; tag = "R1"; end
        6'd34: begin er = a - b; eo = out_of_range(sa - sb); tag = "R1"; end
        6'd35: begin er = a - b; tag = "R1"; end
        6'd42: begin er = (sa < sb) ? 32'd1 : 32'd0; tag = "R4"; end
        6'd43: begin er = (a < b) ? 32'd1 : 32'd0; tag = "R5"; end
        6'd36: begin er = a & b; tag = "R6"; end
        6'd37: begin er = a | b; tag = "R6"; end
        6'd38: begin er = a ^ b; tag = "R6"; end
        6'd39: begin er = ~(a | b); tag = "R6"; end
        default: ers = 1'b1;
      endcase
    end else begin
      case (opc)
        6'd8:  begin er = a + sx; eo = out_of_range(sa + si); tag = "R7"; end
        6'd9:  begin er = a + sx; tag = "R7"; end
        6'd10: begin er = (sa < si) ? 32'd1 : 32'd0; tag = "R4"; end
        6'd11: begin er = (a < sx) ? 32'd1 : 32'd0; tag = "R5"; end
        6'd12: begin er = a & zx; tag = "R8"; end
        6'd13: begin er = a | zx; tag = "R8"; end
        6'd14: begin er = a ^ zx; tag = "R8"; end
        6'd15: begin er = {im, 16'h0000}; tag = "R9"; end
        default: ers = 1'b1;
      endcase
    end
    ewe = !ers && !eo;
  endtask

  task automatic apply(input logic [5:0] opc, input logic [5:0] fnc,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im);
    logic [31:0] er;
    logic eo, ers, ewe;
    string tag;
    @(negedge clk);
    op_code = opc; fn_code = fnc; src_a = a; src_b = b; imm16 = im;
    model(opc, fnc, a, b, im, er, eo, ers, ewe, tag);
    #1;
    n_vec++;
    if (result !== er) begin
      n_bad++;
      $display("FAIL %s result op=%0d fn=%0d a=%h b=%h imm=%h: got %h exp %h",
               tag, opc, fnc, a, b, im, result, er);
    end
    if (ovf_trap !== eo) begin
      n_bad++;
      $display("FAIL %s ovf_trap op=%0d fn=%0d a=%h b=%h imm=%h: got %b exp %b",
               eo ? "R2" : "R3", opc, fnc, a, b, im, ovf_trap, eo);
    end
    if (rsvd_insn !== ers) begin
      n_bad++;
      $display("FAIL R10 rsvd_insn op=%0d fn=%0d: got %b exp %b", opc, fnc, rsvd_insn, ers);
    end
    if (wr_en !== ewe) begin
      n_bad++;
      $display("FAIL R11 wr_en op=%0d fn=%0d a=%h b=%h imm=%h: got %b exp %b",
               opc, fnc, a, b, im, wr_en, ewe);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_vec = 0; n_bad = 0; finished = 1'b0;
    op_code = '0; fn_code = '0; src_a = '0; src_b = '0; imm16 = '0;
    // Idle state: all-zero inputs decode as reserved (R10)
    apply(6'd0, 6'd0, 32'h0, 32'h0, 16'h0);
    // Directed boundaries for R2 and R3
    apply(6'd0, 6'd32, 32'h7FFF_FFFF, 32'h1, 16'h0);       // add overflows
    apply(6'd0, 6'd33, 32'h7FFF_FFFF, 32'h1, 16'h0);       // addu never traps
    apply(6'd0, 6'd34, 32'h8000_0000, 32'h1, 16'h0);       // sub overflows
    apply(6'd0, 6'd34, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0); // sub at edge, no trap
    apply(6'd8, 6'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001);     // addi overflows
    apply(6'd9, 6'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001);     // addiu never traps
    apply(6'd11, 6'd0, 32'h0000_0005, 32'h0, 16'hFFFF);    // sltiu vs 0xFFFFFFFF (R5)
    // Function sweep under opcode 000000: R1, R4, R5, R6, R10, R11
    for (int f = 0; f < 64; f++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          apply(6'd0, 6'(f), vals[i], vals[j], imms[(i + j) % 12]);
    // Opcode sweep: immediates R7, R8, R9 and reserved opcodes R10; src_b varies to show it is ignored
    for (int o = 1; o < 64; o++)
      for (int i = 0; i < 12; i++)
        for (int k = 0; k < 12; k++)
          apply(6'(o), 6'((o + k) % 64), vals[i], vals[(k + 5) % 12], imms[k]);
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout exp completion");
    finish_run();
  end

endmodule